// File: doc/BRIEF.md
# Odd/Even Split Buffer Serial Dumper

After reset this block produces the byte values 0 to 99 once, in ascending order, and sorts them as they stream past. Odd values go into one on-chip buffer and even values into another, so each buffer ends up holding 50 entries at addresses 0 to 49. Two active-low push buttons then request a dump. The odd button sends the odd buffer out over a single asynchronous serial line, and the even button sends the even buffer. Each button has its own debounce filter.

Two independent controllers share one transmitter. Ownership of the transmitter follows controller state: while a controller is preparing, loading or sending, its start strobe and data byte are routed to the framer. At all other times the routing register holds its last value. A controller issues the next byte only after the framer reports that the previous frame is done. Buffers are kept after a dump, so the same button can be pressed again to repeat it.

Top module: `split_dump_top`

## Requirements
- R1: Out of reset the serial line is high, and no frame is sent until a button is pressed.
- R2: A button pulse is accepted only after the input has been seen low for DB_CYCLES consecutive cycles (after a two-flop synchronizer). A shorter press has no effect. A longer hold gives exactly one dump, with no repeats.
- R3: A press of the odd button (key_odd_ni) sends exactly 50 frames carrying 1, 3, 5, ..., 99 in that order.
- R4: A press of the even button (key_even_ni) sends exactly 50 frames carrying 0, 2, 4, ..., 98 in that order.
- R5: Frames of one dump never overlap. The start of each frame follows the start of the previous one by at least 11 bit periods, and a new frame begins only after the framer's done pulse.
- R6: Each frame is 11 bits, each lasting CLK_HZ/BAUD cycles, in this order: a start bit of 0, eight data bits with the LSB first, a parity bit, and a stop bit of 1.
- R7: With ODD_PARITY=0 (the default), the parity bit is the XOR of the eight data bits. With ODD_PARITY=1 it is the inverse of that XOR.
- R8: A press of either button while a dump is in progress is dropped. Only the frames of the running dump appear.
- R9: If both debounced pulses arrive in the same cycle, the odd dump runs and the even request is dropped.
- R10: Buffer contents survive a dump, so a later press of the same button sends the same 50 values again.
- R11: Between frames and between dumps the serial line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| key_odd_ni | input | 1 | Active-low button that requests the odd-value dump |
| key_even_ni | input | 1 | Active-low button that requests the even-value dump |
| tx_o | output | 1 | Serial output line, idles high |

## Verification
Most faults in the controllers show up at the serial line within one dump. A wrong buffer address or a sort fault produces a wrong or out-of-order value in the very first frame that uses the bad entry. A controller that misses or double-counts the done pulse either stops the dump short or skips values, and this is visible as a frame count other than 50. A routing fault shows up as frames from the wrong buffer. A debounce or arbitration fault shows up as a dump that appears when it should not, or fails to appear, within one debounce window plus a few cycles of the press.

// File: rtl/split_dump_pkg.sv
package split_dump_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned FRAME_BITS = 11;

  typedef enum logic [2:0] {
    ST_FILL,
    ST_IDLE,
    ST_PREP,
    ST_LOAD,
    ST_SEND
  } buf_state_e;
endpackage

// File: rtl/key_filter.sv
module key_filter #(
  parameter int unsigned DB_CYCLES = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_ni,
  output logic pulse_o
);
  localparam int unsigned CW = (DB_CYCLES > 2) ? $clog2(DB_CYCLES) : 2;
  localparam logic [CW-1:0] CNT_MAX = CW'(DB_CYCLES - 1);
  localparam logic [CW-1:0] CNT_HIT = CW'(DB_CYCLES - 2);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] cnt_q;
  logic          low;

  assign low = ~sync2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      sync1_q <= key_ni;
      sync2_q <= sync1_q;
      pulse_o <= low && (cnt_q == CNT_HIT);
      if (!low)
        cnt_q <= '0;
      else if (cnt_q != CNT_MAX)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: a held key yields one pulse, never two in a row
  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/sort_buffer.sv
module sort_buffer
  import split_dump_pkg::*;
#(
  parameter int unsigned DEPTH = 50,
  parameter bit          SEL   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              go_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              start_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  buf_state_e        state_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  logic              wr_en;

  assign wr_en  = (state_q == ST_FILL) && in_valid_i && (in_data_i[0] == SEL);
  assign busy_o = (state_q == ST_PREP) || (state_q == ST_LOAD) || (state_q == ST_SEND);

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[addr_q] <= in_data_i;
    mem_q <= mem[addr_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FILL;
      addr_q  <= '0;
      start_o <= 1'b0;
      data_o  <= '0;
    end else begin
      start_o <= 1'b0;
      unique case (state_q)
        ST_FILL: if (wr_en) begin
          if (addr_q == LAST) state_q <= ST_IDLE;
          else                addr_q  <= addr_q + 1'b1;
        end
        ST_IDLE: if (go_i) begin
          addr_q  <= '0;
          state_q <= ST_PREP;
        end
        ST_PREP: state_q <= ST_LOAD;   // read issued, mem_q valid next cycle
        ST_LOAD: begin
          data_o  <= mem_q;
          start_o <= 1'b1;
          state_q <= ST_SEND;
        end
        ST_SEND: if (done_i) begin
          if (addr_q == LAST) state_q <= ST_IDLE;
          else begin
            addr_q  <= addr_q + 1'b1;
            state_q <= ST_PREP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: start strobe is a single cycle
  a_r5_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R3: read/write address never leaves the buffer
  a_r3_addr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= LAST);
  // R5: no new byte loaded while a frame is outstanding
  a_r5_wait_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEND && !done_i) |=> state_q == ST_SEND);
endmodule

// File: rtl/serial_framer.sv
module serial_framer
  import split_dump_pkg::*;
#(
  parameter int unsigned BIT_CYCLES = 434,
  parameter bit          ODD_PARITY = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              tx_o,
  output logic              done_o
);
  localparam int unsigned CW = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 2;
  localparam logic [CW-1:0] CNT_LAST = CW'(BIT_CYCLES - 1);
  localparam logic [3:0]    IDX_LAST = 4'(FRAME_BITS - 1);

  logic              start_d, active_q;
  logic [3:0]        idx_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] byte_q;
  logic              edge_det, bit_end;

  assign edge_det = start_i & ~start_d;
  assign bit_end  = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_d  <= 1'b0;
      active_q <= 1'b0;
      idx_q    <= '0;
      cnt_q    <= '0;
      byte_q   <= '0;
    end else begin
      start_d <= start_i;
      if (!active_q) begin
        if (edge_det) begin
          active_q <= 1'b1;
          idx_q    <= '0;
          cnt_q    <= '0;
          byte_q   <= data_i;
        end
      end else if (bit_end) begin
        cnt_q <= '0;
        if (idx_q == IDX_LAST) active_q <= 1'b0;
        else                   idx_q    <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    tx_o = 1'b1;
    if (active_q) begin
      if (idx_q == 4'd0)                          tx_o = 1'b0;
      else if (idx_q <= 4'(DATA_W))               tx_o = byte_q[3'(idx_q - 4'd1)];
      else if (idx_q == 4'(DATA_W + 1))           tx_o = (^byte_q) ^ ODD_PARITY;
      else                                        tx_o = 1'b1;
    end
  end

  assign done_o = active_q && (idx_q == IDX_LAST) && bit_end;

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6: the line only moves at bit boundaries
  a_r6_bit_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q != '0) |-> $stable(tx_o));
  // R11: the line is high whenever no frame is in flight
  a_r11_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> tx_o);
endmodule

// File: rtl/split_dump_top.sv
module split_dump_top
  import split_dump_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned BAUD        = 115_200,
  parameter int unsigned DB_CYCLES   = 1_000_000,
  parameter int unsigned VALUE_COUNT = 100,
  parameter bit          ODD_PARITY  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_odd_ni,
  input  logic key_even_ni,
  output logic tx_o
);
  localparam int unsigned BIT_CYCLES = CLK_HZ / BAUD;
  localparam int unsigned DEPTH      = VALUE_COUNT / 2;
  localparam int unsigned SW         = $clog2(VALUE_COUNT + 1);
  localparam int unsigned NBUF       = 2;   // index 0: odd, 1: even

  logic [NBUF-1:0]   key_n, key_pulse, go, busy, start;
  logic [DATA_W-1:0] data [NBUF];
  logic [SW-1:0]     src_q;
  logic              src_valid, tx_free, done;
  logic              mux_start_q;
  logic [DATA_W-1:0] mux_data_q;

  assign key_n = {key_even_ni, key_odd_ni};

  // value source: 0..VALUE_COUNT-1 once after reset
  assign src_valid = (src_q < SW'(VALUE_COUNT));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        src_q <= '0;
    else if (src_valid) src_q <= src_q + 1'b1;
  end

  // odd request wins a same-cycle tie
  assign tx_free = ~|busy;
  assign go[0]   = key_pulse[0] & tx_free;
  assign go[1]   = key_pulse[1] & tx_free & ~key_pulse[0];

  for (genvar g = 0; g < NBUF; g++) begin : g_lane
    key_filter #(.DB_CYCLES(DB_CYCLES)) u_key (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .key_ni (key_n[g]),
      .pulse_o(key_pulse[g])
    );
    sort_buffer #(.DEPTH(DEPTH), .SEL(g == 0)) u_buf (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .in_valid_i(src_valid),
      .in_data_i (DATA_W'(src_q)),
      .go_i      (go[g]),
      .done_i    (done),
      .busy_o    (busy[g]),
      .start_o   (start[g]),
      .data_o    (data[g])
    );
  end

  // transmitter ownership follows controller state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mux_start_q <= 1'b0;
      mux_data_q  <= '0;
    end else if (busy[0]) begin
      mux_start_q <= start[0];
      mux_data_q  <= data[0];
    end else if (busy[1]) begin
      mux_start_q <= start[1];
      mux_data_q  <= data[1];
    end
  end

  serial_framer #(.BIT_CYCLES(BIT_CYCLES), .ODD_PARITY(ODD_PARITY)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(mux_start_q),
    .data_i (mux_data_q),
    .tx_o   (tx_o),
    .done_o (done)
  );

  // R8: only one controller owns the transmitter
  a_r8_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy[0] && busy[1]));
  // R9: a tie grants the odd side only
  a_r9_tie_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_pulse[0] && key_pulse[1]) |-> !go[1]);
endmodule

// File: tb/sim_split_dump_top.sv
module sim_split_dump_top;
  localparam int BITC = 8;
  localparam int DB   = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic key_odd_n = 1'b1;
  logic key_even_n = 1'b1;
  logic tx;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  logic [7:0] got[$];
  int frame_errs = 0;
  int min_gap = 1 << 30;
  int last_start = -1;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  split_dump_top #(.CLK_HZ(800), .BAUD(100), .DB_CYCLES(DB)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .key_odd_ni(key_odd_n),
    .key_even_ni(key_even_n), .tx_o(tx)
  );

  // line decoder: samples mid-bit on falling clock edges
  always begin
    @(negedge clk);
    if (rst_ni && tx === 1'b0) begin
      logic [9:0] bits;
      if (last_start >= 0 && cyc - last_start < min_gap) min_gap = cyc - last_start;
      last_start = cyc;
      repeat (BITC / 2) @(negedge clk);
      if (tx !== 1'b0) frame_errs++;
      for (int k = 0; k < 10; k++) begin
        repeat (BITC) @(negedge clk);
        bits[k] = tx;
      end
      if (bits[8] !== ^bits[7:0]) frame_errs++;   // even parity
      if (bits[9] !== 1'b1) frame_errs++;         // stop bit
      got.push_back(bits[7:0]);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic press(input bit odd, input bit even, input int hold);
    @(negedge clk);
    if (odd) key_odd_n = 1'b0;
    if (even) key_even_n = 1'b0;
    repeat (hold) @(negedge clk);
    key_odd_n = 1'b1;
    key_even_n = 1'b1;
  endtask

  task automatic expect_dump(input bit odd_vals, input string req);
    chk(got.size() == 50, {req, " frame count"}, got.size(), 50);
    for (int i = 0; i < 50 && i < got.size(); i++)
      chk(int'(got[i]) == 2 * i + (odd_vals ? 1 : 0), req, got[i], 2 * i + (odd_vals ? 1 : 0));
    chk(frame_errs == 0, "R6/R7 start/parity/stop", frame_errs, 0);
    chk(min_gap >= 11 * BITC, "R5 frame spacing", min_gap, 11 * BITC);
    chk(tx === 1'b1, "R11 line high after dump", tx, 1);
  endtask

  task automatic clear_rx();
    got.delete();
    frame_errs = 0;
    min_gap = 1 << 30;
    last_start = -1;
  endtask

  task automatic t_reset();
    bit seen_low = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tx !== 1'b1) seen_low = 1;
    end
    chk(!seen_low, "R1 idle line after reset", seen_low, 0);
    chk(got.size() == 0, "R1 no frames after reset", got.size(), 0);
  endtask

  task automatic t_short_press();
    clear_rx();
    press(1, 0, DB - 6);
    repeat (600) @(negedge clk);
    chk(got.size() == 0, "R2 short press ignored", got.size(), 0);
  endtask

  task automatic t_odd_dump();
    clear_rx();
    press(1, 0, 300);        // long hold: still a single dump (R2)
    repeat (6000) @(negedge clk);
    expect_dump(1, "R3 odd values");
    chk(got.size() == 50, "R2 long hold gives one dump", got.size(), 50);
  endtask

  task automatic t_even_dump();
    clear_rx();
    press(0, 1, 40);
    repeat (5500) @(negedge clk);
    expect_dump(0, "R4 even values");
  endtask

  task automatic t_overlap();
    clear_rx();
    press(1, 0, 40);
    repeat (800) @(negedge clk);
    press(0, 1, 40);
    repeat (5500) @(negedge clk);
    expect_dump(1, "R8 press during dump dropped");
  endtask

  task automatic t_both();
    clear_rx();
    press(1, 1, 40);
    repeat (5500) @(negedge clk);
    expect_dump(1, "R9 tie goes to odd, R10 repeat dump");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_short_press();
    t_odd_dump();
    t_even_dump();
    t_overlap();
    t_both();
    t_even_dump();           // R10: even buffer kept too
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule